// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block moves a processor core from ordinary execution into a trap or interrupt handler. A request arrives with a class code, a trap identification number (TIN) and the program counter of the interrupted instruction. The block snapshots the architectural registers it will modify when it accepts the request. It then asks an external unit to store the upper context and waits until that unit reports completion. After that it computes the new register values and the handler fetch address. It presents all of them together with a one-cycle `done` pulse and holds them stable until the next trap completes.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A requester that sees `req_ready` low must hold `req_valid` and the payload until `req_ready` returns. Payloads presented while the block is busy have no effect. The context-save side is a plain level handshake. `save_req` stays high until the save unit asserts `save_done` for one cycle, and that unit may answer in the same cycle that `save_req` first appears.

Class codes: 0 to 7 are synchronous traps, 3 is context management, 6 is system call, and 8 is an external interrupt. TIN 1 on class 3 means the free list is nearly depleted (FCD). TIN 4 on class 3 means the free list is empty (FCU).

Top module: `trap_entry_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request held valid while the block is busy is not taken, and it does not alter the trap in progress. It is taken on the first edge after the block has returned to idle.
- R2: For classes 0 to 7, `new_pc` equals BTV OR (class << 5).
- R3: For class 8, `new_pc` equals BIV OR (ICR[23:16] << 6). ICR[23:16] is the pending interrupt priority.
- R4: `d15_o` equals the TIN, zero-extended, for every legal trap.
- R5: `save_req` rises in the cycle after acceptance and stays high until `save_done`. It is never raised for class 3 with TIN 4. In that case the outputs appear two cycles after acceptance.
- R6: `a11_o` equals PC + 4 for class 6 and equals PC for every other class, apart from the case in R7.
- R7: For class 3 with TIN 1, `a11_o` equals BTV OR (3 << 5) and SYSCON bit 0 is set. All other SYSCON bits pass through unchanged in every case.
- R8: If PSW bit 9 (interrupt-stack flag) was 0 on entry, `a10_o` equals ISP. Otherwise A10 keeps its value. PSW bit 9 is 1 on exit.
- R9: On exit, PSW[13:12] = 0, PSW[11:10] = 2'b10, bit 8 = 0, bit 7 = 1 and PSW[6:0] = 0. PSW bits 31:14 are kept.
- R10: PCXI bit 23 takes the old ICR bit 8 (interrupt enable), and PCXI[31:24] takes ICR[7:0] (current priority). All other PCXI bits are kept. ICR bit 8 is cleared and all other ICR bits are kept.
- R11: A class above 8 is accepted and then rejected. `err` pulses for one cycle, in the cycle after acceptance. No `save_req` or `done` follows, and every output register keeps its previous value.
- R12: `done` is a one-cycle pulse two cycles after the edge that samples `save_done`. All outputs are valid while it is high and stay unchanged until the next legal trap completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_class | input | CLASS_W | Trap class code |
| req_tin | input | TIN_W | Trap identification number |
| req_pc | input | XLEN | PC of the interrupted instruction |
| psw_i | input | XLEN | Current program status word |
| icr_i | input | XLEN | Current interrupt control register |
| pcxi_i | input | XLEN | Current previous-context register |
| a10_i | input | XLEN | Current stack pointer |
| isp_i | input | XLEN | Interrupt stack pointer |
| btv_i | input | XLEN | Trap vector base |
| biv_i | input | XLEN | Interrupt vector base |
| syscon_i | input | XLEN | Current system configuration register |
| save_req | output | 1 | Upper-context save request |
| save_done | input | 1 | Upper-context save finished |
| done | output | 1 | Entry complete, outputs valid |
| err | output | 1 | Illegal class rejected |
| new_pc | output | XLEN | Handler fetch address |
| psw_o | output | XLEN | New program status word |
| icr_o | output | XLEN | New interrupt control register |
| pcxi_o | output | XLEN | New previous-context register |
| a10_o | output | XLEN | New stack pointer |
| a11_o | output | XLEN | Return address |
| d15_o | output | XLEN | TIN for the handler |
| syscon_o | output | XLEN | New system configuration register |

## Verification
Two pairs of events can fall in the same cycle. The first is the `done` pulse and a waiting back-pressured request. The second is the rise of `save_req` and an immediate `save_done`. To provoke the first, a second request with a different class is held valid throughout a trap. The bench judges that the first trap's outputs are intact, that `req_ready` stays low through `done`, and that the second trap then completes with its own vector. To provoke the second, the save unit answers with zero latency. The bench confirms that `done` still arrives exactly two edges after `save_done` is sampled.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SAVE_WAIT = 2'd1,
    ST_UPDATE    = 2'd2,
    ST_DONE      = 2'd3
  } tes_state_e;

  // class codes whose behaviour is special
  localparam int CLS_CTXMGT  = 3;
  localparam int CLS_SYSCALL = 6;
  localparam int CLS_IRQ     = 8;
  localparam int CLS_MAX     = 8;

  // context management TIN codes
  localparam int TIN_FCD = 1;
  localparam int TIN_FCU = 4;

  // status word layout
  localparam int PSW_PRS_LO = 12;
  localparam int PSW_IO_LO  = 10;
  localparam int PSW_IS     = 9;
  localparam int PSW_GW     = 8;
  localparam int PSW_CDE    = 7;
  localparam int PSW_CDC_W  = 7;
  localparam logic [1:0] PSW_IO_SUPER = 2'b10;

  // interrupt control layout
  localparam int ICR_CCPN_W  = 8;
  localparam int ICR_IE      = 8;
  localparam int ICR_PIPN_LO = 16;
  localparam int ICR_PIPN_W  = 8;
  localparam int IRQ_VEC_RSH = 10;

  // previous context layout
  localparam int PCXI_PIE     = 23;
  localparam int PCXI_PCPN_LO = 24;

  localparam int SYSCON_FCDSF = 0;
  localparam int TRAP_VEC_SH  = 5;
  localparam int SYSCALL_STEP = 4;

endpackage

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CLASS_W = 4
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic [XLEN-1:0]    btv,
  input  logic [XLEN-1:0]    biv,
  input  logic [XLEN-1:0]    icr,
  output logic [XLEN-1:0]    vec
);
  localparam logic [XLEN-1:0] PIPN_MASK =
    XLEN'({ICR_PIPN_W{1'b1}}) << ICR_PIPN_LO;

  logic [XLEN-1:0] trap_vec;
  logic [XLEN-1:0] irq_vec;

  always_comb begin
    trap_vec = btv | (XLEN'(cls) << TRAP_VEC_SH);
    irq_vec  = biv | ((icr & PIPN_MASK) >> IRQ_VEC_RSH);
    vec      = (cls == CLASS_W'(CLS_IRQ)) ? irq_vec : trap_vec;
  end
endmodule

// File: rtl/trap_ctx_update.sv
module trap_ctx_update
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CLASS_W = 4,
  parameter int TIN_W   = 8
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic [TIN_W-1:0]   tin,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    vec,
  input  logic [XLEN-1:0]    psw,
  input  logic [XLEN-1:0]    icr,
  input  logic [XLEN-1:0]    pcxi,
  input  logic [XLEN-1:0]    a10,
  input  logic [XLEN-1:0]    isp,
  input  logic [XLEN-1:0]    syscon,
  output logic [XLEN-1:0]    nx_psw,
  output logic [XLEN-1:0]    nx_icr,
  output logic [XLEN-1:0]    nx_pcxi,
  output logic [XLEN-1:0]    nx_a10,
  output logic [XLEN-1:0]    nx_a11,
  output logic [XLEN-1:0]    nx_d15,
  output logic [XLEN-1:0]    nx_syscon
);
  logic is_fcd;
  logic is_sys;

  always_comb begin
    is_fcd = (cls == CLASS_W'(CLS_CTXMGT)) && (tin == TIN_W'(TIN_FCD));
    is_sys = (cls == CLASS_W'(CLS_SYSCALL));

    // status word: supervisor, interrupt stack, fresh call depth
    nx_psw = psw;
    nx_psw[PSW_PRS_LO +: 2]    = 2'b00;
    nx_psw[PSW_IO_LO +: 2]     = PSW_IO_SUPER;
    nx_psw[PSW_IS]             = 1'b1;
    nx_psw[PSW_GW]             = 1'b0;
    nx_psw[PSW_CDE]            = 1'b1;
    nx_psw[PSW_CDC_W-1:0]      = '0;

    nx_icr         = icr;
    nx_icr[ICR_IE] = 1'b0;

    nx_pcxi                                 = pcxi;
    nx_pcxi[PCXI_PIE]                       = icr[ICR_IE];
    nx_pcxi[PCXI_PCPN_LO +: ICR_CCPN_W]     = icr[ICR_CCPN_W-1:0];

    nx_a10 = psw[PSW_IS] ? a10 : isp;

    if (is_fcd)      nx_a11 = vec;
    else if (is_sys) nx_a11 = pc + XLEN'(SYSCALL_STEP);
    else             nx_a11 = pc;

    nx_d15 = XLEN'(tin);

    nx_syscon = syscon;
    if (is_fcd) nx_syscon[SYSCON_FCDSF] = 1'b1;
  end
endmodule

// File: rtl/trap_entry_fsm.sv
module trap_entry_fsm
  import trap_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic legal,
  input  logic skip_save,
  input  logic save_done,
  output logic req_ready,
  output logic save_req,
  output logic load_out,
  output logic done,
  output logic err
);
  tes_state_e state_q, state_d;
  logic err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && legal) state_d = skip_save ? ST_UPDATE : ST_SAVE_WAIT;
      ST_SAVE_WAIT: if (save_done) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept && !legal;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign save_req  = (state_q == ST_SAVE_WAIT);
  assign load_out  = (state_q == ST_UPDATE);
  assign done      = (state_q == ST_DONE);
  assign err       = err_q;

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal) |=> !req_ready);
  assert_save_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_done) |=> save_req);
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CLASS_W = 4,
  parameter int TIN_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CLASS_W-1:0] req_class,
  input  logic [TIN_W-1:0]   req_tin,
  input  logic [XLEN-1:0]    req_pc,
  input  logic [XLEN-1:0]    psw_i,
  input  logic [XLEN-1:0]    icr_i,
  input  logic [XLEN-1:0]    pcxi_i,
  input  logic [XLEN-1:0]    a10_i,
  input  logic [XLEN-1:0]    isp_i,
  input  logic [XLEN-1:0]    btv_i,
  input  logic [XLEN-1:0]    biv_i,
  input  logic [XLEN-1:0]    syscon_i,
  output logic               save_req,
  input  logic               save_done,
  output logic               done,
  output logic               err,
  output logic [XLEN-1:0]    new_pc,
  output logic [XLEN-1:0]    psw_o,
  output logic [XLEN-1:0]    icr_o,
  output logic [XLEN-1:0]    pcxi_o,
  output logic [XLEN-1:0]    a10_o,
  output logic [XLEN-1:0]    a11_o,
  output logic [XLEN-1:0]    d15_o,
  output logic [XLEN-1:0]    syscon_o
);
  logic accept, legal, skip_save, load_out;

  logic [CLASS_W-1:0] c_cls;
  logic [TIN_W-1:0]   c_tin;
  logic [XLEN-1:0]    c_pc, c_psw, c_icr, c_pcxi, c_a10, c_isp, c_btv, c_biv, c_sys;

  logic [XLEN-1:0] vec;
  logic [XLEN-1:0] nx_psw, nx_icr, nx_pcxi, nx_a10, nx_a11, nx_d15, nx_sys;

  assign accept    = req_valid && req_ready;
  assign legal     = (req_class <= CLASS_W'(CLS_MAX));
  assign skip_save = (req_class == CLASS_W'(CLS_CTXMGT)) && (req_tin == TIN_W'(TIN_FCU));

  // snapshot of the request and architectural state at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_cls <= '0; c_tin <= '0; c_pc <= '0;
      c_psw <= '0; c_icr <= '0; c_pcxi <= '0; c_a10 <= '0;
      c_isp <= '0; c_btv <= '0; c_biv <= '0; c_sys <= '0;
    end else if (accept && legal) begin
      c_cls <= req_class; c_tin <= req_tin; c_pc <= req_pc;
      c_psw <= psw_i; c_icr <= icr_i; c_pcxi <= pcxi_i; c_a10 <= a10_i;
      c_isp <= isp_i; c_btv <= btv_i; c_biv <= biv_i; c_sys <= syscon_i;
    end
  end

  trap_entry_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .legal     (legal),
    .skip_save (skip_save),
    .save_done (save_done),
    .req_ready (req_ready),
    .save_req  (save_req),
    .load_out  (load_out),
    .done      (done),
    .err       (err)
  );

  trap_vector_calc #(.XLEN(XLEN), .CLASS_W(CLASS_W)) u_vec (
    .cls (c_cls),
    .btv (c_btv),
    .biv (c_biv),
    .icr (c_icr),
    .vec (vec)
  );

  trap_ctx_update #(.XLEN(XLEN), .CLASS_W(CLASS_W), .TIN_W(TIN_W)) u_upd (
    .cls       (c_cls),
    .tin       (c_tin),
    .pc        (c_pc),
    .vec       (vec),
    .psw       (c_psw),
    .icr       (c_icr),
    .pcxi      (c_pcxi),
    .a10       (c_a10),
    .isp       (c_isp),
    .syscon    (c_sys),
    .nx_psw    (nx_psw),
    .nx_icr    (nx_icr),
    .nx_pcxi   (nx_pcxi),
    .nx_a10    (nx_a10),
    .nx_a11    (nx_a11),
    .nx_d15    (nx_d15),
    .nx_syscon (nx_sys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_pc <= '0; psw_o <= '0; icr_o <= '0; pcxi_o <= '0;
      a10_o <= '0; a11_o <= '0; d15_o <= '0; syscon_o <= '0;
    end else if (load_out) begin
      new_pc <= vec; psw_o <= nx_psw; icr_o <= nx_icr; pcxi_o <= nx_pcxi;
      a10_o <= nx_a10; a11_o <= nx_a11; d15_o <= nx_d15; syscon_o <= nx_sys;
    end
  end

  assert_no_save_on_fcu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> !((c_cls == CLASS_W'(CLS_CTXMGT)) && (c_tin == TIN_W'(TIN_FCU))));
  assert_is_set_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> psw_o[PSW_IS]);
  assert_ie_off_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !icr_o[ICR_IE]);
  assert_err_keeps_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(new_pc) && !save_req && !done));
endmodule

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam logic [31:0] BTV = 32'h8000_0000;
  localparam logic [31:0] BIV = 32'hA000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_class = '0;
  logic [7:0] req_tin = '0;
  logic [31:0] req_pc = '0, psw_i = '0, icr_i = '0, pcxi_i = '0, a10_i = '0;
  logic [31:0] isp_i = 32'hC000_0F00, btv_i = BTV, biv_i = BIV, syscon_i = '0;
  logic save_req, done, err;
  logic save_done = 1'b0;
  logic [31:0] new_pc, psw_o, icr_o, pcxi_o, a10_o, a11_o, d15_o, syscon_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_tin(req_tin), .req_pc(req_pc),
    .psw_i(psw_i), .icr_i(icr_i), .pcxi_i(pcxi_i), .a10_i(a10_i), .isp_i(isp_i),
    .btv_i(btv_i), .biv_i(biv_i), .syscon_i(syscon_i),
    .save_req(save_req), .save_done(save_done), .done(done), .err(err),
    .new_pc(new_pc), .psw_o(psw_o), .icr_o(icr_o), .pcxi_o(pcxi_o),
    .a10_o(a10_o), .a11_o(a11_o), .d15_o(d15_o), .syscon_o(syscon_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [3:0] c, input logic [7:0] t,
                               input logic [31:0] pc, psw, icr, pcxi, a10, sys);
    logic [31:0] e_pc, e_a11, e_sys;
    if (c == 4'd8) e_pc = BIV + 32'(icr[23:16]) * 64;
    else           e_pc = BTV + 32'(c) * 32;
    chk(c == 4'd8 ? "R3 vector" : "R2 vector", new_pc, e_pc);
    chk("R4 d15", d15_o, 32'(t));
    e_sys = sys;
    if (c == 4'd3 && t == 8'd1) begin
      e_a11 = BTV + 32'd96;
      e_sys = sys | 32'd1;
    end else if (c == 4'd6) e_a11 = pc + 32'd4;
    else e_a11 = pc;
    chk((c == 4'd3 && t == 8'd1) ? "R7 a11" : "R6 a11", a11_o, e_a11);
    chk("R7 syscon", syscon_o, e_sys);
    chk("R8 a10", a10_o, psw[9] ? a10 : isp_i);
    chk("R9 psw", psw_o, (psw & 32'hFFFF_C000) | 32'h0000_0A80);
    chk("R10 icr", icr_o, icr & ~32'h0000_0100);
    chk("R10 pcxi", pcxi_o, (32'(icr[7:0]) << 24) | (32'(icr[8]) << 23) | (pcxi & 32'h007F_FFFF));
  endtask

  // full trap: drive, accept, save handshake with given latency, check
  task automatic run_trap(input logic [3:0] c, input logic [7:0] t, input int lat);
    logic [31:0] pc, psw, icr, pcxi, a10, sys;
    logic [31:0] p_pc, p_d15, p_a11;
    bit need_save;
    int guard;
    need_save = !(c == 4'd3 && t == 8'd4);
    pc = req_pc; psw = psw_i; icr = icr_i; pcxi = pcxi_i; a10 = a10_i; sys = syscon_i;
    p_pc = new_pc; p_d15 = d15_o; p_a11 = a11_o;
    @(negedge clk);
    req_class = c; req_tin = t; req_valid = 1'b1;
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (c > 4'd8) begin
      chk("R11 err pulse", {31'd0, err}, 32'd1);
      chk("R11 no save", {31'd0, save_req}, 32'd0);
      chk("R11 pc kept", new_pc, p_pc);
      chk("R11 d15 kept", d15_o, p_d15);
      chk("R11 a11 kept", a11_o, p_a11);
      @(negedge clk);
      chk("R11 err single", {31'd0, err}, 32'd0);
      chk("R11 no done", {30'd0, done, save_req}, 32'd0);
      chk("R1 ready after err", {31'd0, req_ready}, 32'd1);
      return;
    end
    if (need_save) begin
      chk("R5 save raised", {31'd0, save_req}, 32'd1);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk("R5 save held", {30'd0, save_req, done}, 32'd2);
      end
      save_done = 1'b1;
      @(negedge clk);
      save_done = 1'b0;
      chk("R12 no early done", {30'd0, done, save_req}, 32'd0);
    end else begin
      chk("R5 save skipped", {31'd0, save_req}, 32'd0);
      chk("R5 no early done", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    chk("R12 done", {31'd0, done}, 32'd1);
    check_outputs(c, t, pc, psw, icr, pcxi, a10, sys);
    @(negedge clk);
    chk("R12 done single", {31'd0, done}, 32'd0);
    chk("R1 ready back", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset flags", {29'd0, done, err, save_req}, 32'd0);
    chk("R2 reset pc", new_pc, 32'd0);

    // sweep of every legal class, alternating stack flag and latency
    for (int c = 0; c <= 8; c++) begin
      req_pc   = 32'h0001_0000 + 32'(c) * 32'h10;
      psw_i    = 32'h1234_0000 | (32'(c & 1) << 9) | 32'h0000_357F;
      icr_i    = (32'(c * 29 + 3) << 16) | (32'(c & 1) << 8) | 32'(c * 17);
      pcxi_i   = 32'h5A5A_5A5A ^ 32'(c);
      a10_i    = 32'hD000_0000 + 32'(c);
      syscon_i = 32'h0000_0F00 | 32'(c << 4);
      run_trap(4'(c), 8'(c + 16), c % 4);
    end

    // context management TIN sweep: FCD and FCU paths
    for (int t = 0; t < 8; t++) begin
      req_pc   = 32'h0002_0000 + 32'(t) * 4;
      psw_i    = (t % 2 == 0) ? 32'h0000_0200 : 32'h0000_0000;
      icr_i    = 32'h0045_01AA;
      syscon_i = 32'h0000_0006;
      run_trap(4'd3, 8'(t), t % 3);
    end

    // interrupt priority sweep
    for (int k = 0; k < 6; k++) begin
      logic [7:0] pr;
      pr = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 :
           (k == 3) ? 8'hFF : 8'(k * 37);
      icr_i = (32'(pr) << 16) | 32'h0000_0155;
      run_trap(4'd8, 8'd0, k % 2);
    end

    // syscall with zero-latency save
    req_pc = 32'hFFFF_FFF0;
    run_trap(4'd6, 8'd42, 0);

    // illegal classes leave outputs untouched
    for (int c = 9; c < 16; c++) run_trap(4'(c), 8'd7, 0);

    // back-pressure: second request held valid through the first trap
    begin
      logic [31:0] f_pc;
      int guard;
      req_pc = 32'h0004_4440; psw_i = 32'h0; icr_i = 32'h0011_0122;
      pcxi_i = 32'h0; syscon_i = 32'h0;
      @(negedge clk);
      req_class = 4'd2; req_tin = 8'd11; req_valid = 1'b1;
      @(negedge clk);
      f_pc = req_pc;
      req_class = 4'd5; req_tin = 8'd99; req_pc = 32'h0009_9990;
      for (int i = 0; i < 3; i++) begin
        chk("R1 busy not ready", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
      end
      save_done = 1'b1;
      @(negedge clk);
      save_done = 1'b0;
      @(negedge clk);
      chk("R1 done with first", {31'd0, done}, 32'd1);
      chk("R1 busy during done", {31'd0, req_ready}, 32'd0);
      chk("R1 first vector kept", new_pc, BTV + 32'd64);
      chk("R1 first tin kept", d15_o, 32'd11);
      chk("R1 first pc kept", a11_o, f_pc);
      @(negedge clk);
      chk("R1 ready for held", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 held taken", {31'd0, save_req}, 32'd1);
      save_done = 1'b1;
      @(negedge clk);
      save_done = 1'b0;
      guard = 0;
      while (!done && guard < 10) begin @(negedge clk); guard++; end
      chk("R1 second vector", new_pc, BTV + 32'd160);
      chk("R1 second tin", d15_o, 32'd99);
      chk("R1 second a11", a11_o, 32'h0009_9990);
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule